// File: doc/BRIEF.md
# DRAM Precharge Spacing Tracker

This block observes the command stream of one DRAM channel and works out, for every rank and bank, whether a PRECHARGE could legally go out in the current cycle. A scheduler places it next to its command arbiter: it reads the `pre_ok` vector before it picks a PRE. Every issued command is also fed back into the block. Three minimum spacings, all counted in DRAM clocks, are held in one packed 16-bit configuration register. The first is the gap from a WRITE to a PRE on the same rank-bank. The second is the gap from a READ to a PRE on the same rank-bank. The third is the gap between two PREs anywhere in the same rank.

Each rank-bank has one down-counter for writes and one for reads. Each rank has one down-counter for precharges. A command reloads its counter with the spacing minus one, so the newest command always defines the constraint. The counter keeps the spacing value it was loaded with, so a later change to the register does not alter it. A PRE that arrives while its bank is blocked moves a small flag machine from state `VIOL_CLEAR` to `VIOL_SET` (transition "early PRE"). The machine stays in `VIOL_SET` until a clear pulse without a new early PRE moves it back (transition "clear"). An early PRE in the same cycle as a clear keeps it in `VIOL_SET`.

Top module: `pchg_timing_tracker`

## Requirements
- R1: After reset the register reads 0x0000, every bit of `pre_ok` is 1 and `viol` is 0.
- R2: A write stores the write-to-PRE spacing in bits 15:11, the read-to-PRE spacing in bits 10:6 and the PRE-to-PRE spacing in bits 5:2. Bits 1:0 always read as zero.
- R3: After a WRITE (cmd_type 2'b10) to a rank-bank at clock edge t, that bank's `pre_ok` bit is 0 until the edge t+G, where G is the write spacing. From edge t+G on, a PRE to that bank is legal.
- R4: After a READ (cmd_type 2'b01), the same rule as R3 applies, using the read spacing.
- R5: After a PRE (cmd_type 2'b11) to a rank, every bank of that rank is blocked for the PRE-to-PRE spacing, counted the same way.
- R6: A command changes the `pre_ok` bits of its own rank-bank only. A PRE is the exception and changes the bits of its own rank. The bit for rank r, bank b sits at index r*8+b.
- R7: A new READ or WRITE to a bank whose counter is still running reloads that counter from the new command.
- R8: A PRE issued while its `pre_ok` bit is 0 sets `viol` on the next cycle, and `viol` stays set. A PRE issued while the bit is 1 does not set it.
- R9: A pulse on `viol_clr` clears `viol`. If an early PRE arrives in the same cycle as the pulse, `viol` stays set.
- R10: Changing the register affects only commands issued after the change. A counter that is already running keeps its loaded value.
- R11: A command with `cmd_valid` low, or with cmd_type 2'b00 (NOP), changes neither `pre_ok` nor `viol`.
- R12: A spacing of 0 or 1 leaves the bank's `pre_ok` bit at 1 in the cycle right after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration readback |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_type | input | 2 | 00 NOP, 01 READ, 10 WRITE, 11 PRE |
| cmd_rank | input | 2 | Target rank |
| cmd_bank | input | 3 | Target bank |
| viol_clr | input | 1 | Write-one pulse that clears the violation flag |
| pre_ok | output | 32 | Per rank-bank PRE allowed, index rank*8+bank |
| viol | output | 1 | Sticky early-precharge flag |

## Verification
The assertions assume that at most one command arrives per clock and that the rank and bank fields are inside the configured counts. They also assume that a PRE marked early is a PRE that was really issued, so the tracker's own `pre_ok` is the reference for legality. The stimulus issues one command at a time from a task that holds the strobe for exactly one edge. It waits long enough between table vectors for every counter to drain, so each vector starts from an all-allowed state. Clear pulses and early PREs are combined only in the directed test that targets their overlap.

// File: rtl/pchg_pkg.sv
package pchg_pkg;
    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_RD  = 2'b01,
        CMD_WR  = 2'b10,
        CMD_PRE = 2'b11
    } cmd_e;

    localparam int GAP_W  = 5;
    localparam int PP_W   = 4;
    localparam int CFG_W  = 16;

    typedef struct packed {
        logic [GAP_W-1:0] wr_gap;
        logic [GAP_W-1:0] rd_gap;
        logic [PP_W-1:0]  pp_gap;
    } gaps_t;

    function automatic logic [GAP_W-1:0] gap_to_load(input logic [GAP_W-1:0] g);
        return (g == '0) ? '0 : GAP_W'(g - 1'b1);
    endfunction
endpackage

// File: rtl/pchg_cfg_reg.sv
module pchg_cfg_reg
    import pchg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output gaps_t            gaps
);
    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (we)
            cfg_q <= wdata & 16'hFFFC;
    end

    assign rdata       = cfg_q;
    assign gaps.wr_gap = cfg_q[15:11];
    assign gaps.rd_gap = cfg_q[10:6];
    assign gaps.pp_gap = cfg_q[5:2];

    // R2: stored value follows the last write with the low pair cleared
    assert_cfg_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q == {$past(wdata[15:2]), 2'b00}));
endmodule

// File: rtl/pchg_down_counter.sv
module pchg_down_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R3: a running counter without a reload drops by exactly one per cycle
    assert_cnt_decay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
    // R7: a reload replaces whatever the counter held
    assert_cnt_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/pchg_viol_fsm.sv
module pchg_viol_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic early_pre,
    input  logic clr,
    output logic viol
);
    typedef enum logic {VIOL_CLEAR, VIOL_SET} viol_st_e;
    viol_st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= VIOL_CLEAR;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            VIOL_CLEAR: if (early_pre) st_d = VIOL_SET;
            VIOL_SET:   if (clr && !early_pre) st_d = VIOL_CLEAR;
            default:    st_d = VIOL_CLEAR;
        endcase
    end

    always_comb begin
        viol = (st_q == VIOL_SET);
    end

    // R8: flag stays set until a clear
    assert_viol_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && !clr) |=> viol);
    // R9: clear without a concurrent early PRE empties the flag
    assert_viol_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !early_pre) |=> !viol);
endmodule

// File: rtl/pchg_timing_tracker.sv
module pchg_timing_tracker
    import pchg_pkg::*;
#(
    parameter int NUM_RANKS = 4,
    parameter int NUM_BANKS = 8,
    localparam int RANK_W   = $clog2(NUM_RANKS),
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int NUM_RB   = NUM_RANKS * NUM_BANKS,
    localparam int IDX_W    = $clog2(NUM_RB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_type,
    input  logic [RANK_W-1:0] cmd_rank,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic              viol_clr,
    output logic [NUM_RB-1:0] pre_ok,
    output logic              viol
);
    gaps_t              gaps;
    logic [GAP_W-1:0]   wr_load_val, rd_load_val;
    logic [PP_W-1:0]    pp_load_val;
    logic               is_rd, is_wr, is_pre;
    logic [IDX_W-1:0]   cmd_idx;
    logic               early_pre;
    logic [NUM_RANKS-1:0] rank_pp_zero;
    logic [NUM_RANKS-1:0] rank_any_ok;

    pchg_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .gaps  (gaps)
    );

    assign is_rd  = cmd_valid && (cmd_e'(cmd_type) == CMD_RD);
    assign is_wr  = cmd_valid && (cmd_e'(cmd_type) == CMD_WR);
    assign is_pre = cmd_valid && (cmd_e'(cmd_type) == CMD_PRE);
    assign cmd_idx = IDX_W'(cmd_rank) * IDX_W'(NUM_BANKS) + IDX_W'(cmd_bank);

    assign wr_load_val = gap_to_load(gaps.wr_gap);
    assign rd_load_val = gap_to_load(gaps.rd_gap);
    assign pp_load_val = PP_W'(gap_to_load(GAP_W'(gaps.pp_gap)));

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        logic hit_rank;
        assign hit_rank = (cmd_rank == RANK_W'(r));

        pchg_down_counter #(.W(PP_W)) u_pp_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (is_pre && hit_rank),
            .load_val (pp_load_val),
            .zero     (rank_pp_zero[r])
        );

        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic hit_rb, wr_zero, rd_zero;
            assign hit_rb = hit_rank && (cmd_bank == BANK_W'(b));

            pchg_down_counter #(.W(GAP_W)) u_wr_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (is_wr && hit_rb),
                .load_val (wr_load_val),
                .zero     (wr_zero)
            );

            pchg_down_counter #(.W(GAP_W)) u_rd_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (is_rd && hit_rb),
                .load_val (rd_load_val),
                .zero     (rd_zero)
            );

            assign pre_ok[r*NUM_BANKS+b] = wr_zero && rd_zero && rank_pp_zero[r];
        end

        assign rank_any_ok[r] = |pre_ok[r*NUM_BANKS +: NUM_BANKS];
    end

    assign early_pre = is_pre && !pre_ok[cmd_idx];

    pchg_viol_fsm u_viol (
        .clk       (clk),
        .rst_n     (rst_n),
        .early_pre (early_pre),
        .clr       (viol_clr),
        .viol      (viol)
    );

    // R3: a write with spacing above one blocks its bank on the next cycle
    assert_wr_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && gaps.wr_gap > 5'd1) |=> !pre_ok[$past(cmd_idx)]);
    // R4: a read with spacing above one blocks its bank on the next cycle
    assert_rd_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && gaps.rd_gap > 5'd1) |=> !pre_ok[$past(cmd_idx)]);
    // R5: a precharge with spacing above one blocks its whole rank
    assert_pp_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre && gaps.pp_gap > 4'd1) |=> !rank_any_ok[$past(cmd_rank)]);
    // R8: an early precharge raises the flag
    assert_early_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        early_pre |=> viol);
endmodule

// File: tb/pchg_timing_tracker_tb.sv
module pchg_timing_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_type = 2'b00;
    logic [1:0]  cmd_rank = '0;
    logic [2:0]  cmd_bank = '0;
    logic        viol_clr = 1'b0;
    logic [31:0] pre_ok;
    logic        viol;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    pchg_timing_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .viol_clr(viol_clr),
        .pre_ok(pre_ok), .viol(viol)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called right after a negedge; returns at the negedge after the issue edge
    task automatic issue(input logic v, input logic [1:0] ty, input int r, input int b,
                         input logic clr);
        cmd_valid = v; cmd_type = ty; cmd_rank = 2'(r); cmd_bank = 3'(b); viol_clr = clr;
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd_type = 2'b00; viol_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic wcfg(input logic [15:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain();
        repeat (35) @(negedge clk);
    endtask

    // {type[1:0], gap[4:0], wait[4:0], expected pre_ok}
    localparam logic [12:0] VECS [12] = '{
        {2'b10, 5'd4,  5'd2,  1'b0},   // R3
        {2'b10, 5'd4,  5'd3,  1'b1},   // R3
        {2'b10, 5'd31, 5'd29, 1'b0},   // R3
        {2'b10, 5'd31, 5'd30, 1'b1},   // R3
        {2'b01, 5'd6,  5'd4,  1'b0},   // R4
        {2'b01, 5'd6,  5'd5,  1'b1},   // R4
        {2'b01, 5'd2,  5'd0,  1'b0},   // R4
        {2'b01, 5'd1,  5'd0,  1'b1},   // R12
        {2'b10, 5'd0,  5'd0,  1'b1},   // R12
        {2'b11, 5'd5,  5'd3,  1'b0},   // R5
        {2'b11, 5'd5,  5'd4,  1'b1},   // R5
        {2'b11, 5'd15, 5'd13, 1'b0}    // R5
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(32'(cfg_rdata), 32'h0, "R1 cfg");
        chk(pre_ok, 32'hFFFF_FFFF, "R1 pre_ok");
        chk(32'(viol), 32'h0, "R1 viol");

        // R2 field packing, low bits read zero
        wcfg(16'hFFFF);
        chk(32'(cfg_rdata), 32'h0000_FFFC, "R2 readback");
        wcfg(16'h0000);

        // Table walk on rank 1 bank 3 (index 11)
        foreach (VECS[i]) begin
            logic [1:0] ty = VECS[i][12:11];
            logic [4:0] g  = VECS[i][10:6];
            logic [4:0] w  = VECS[i][5:1];
            logic       e  = VECS[i][0];
            if (ty == 2'b10)      wcfg({g, 11'b0});
            else if (ty == 2'b01) wcfg({5'b0, g, 6'b0});
            else                  wcfg({10'b0, g[3:0], 2'b0});
            issue(1'b1, ty, 1, 3, 1'b0);
            repeat (w) @(negedge clk);
            chk(32'(pre_ok[11]), 32'(e), "R3/R4/R5/R12 table");
            drain();
        end
        chk(32'(viol), 32'h0, "R8 legal PREs leave flag clear");

        // R6 isolation
        wcfg({5'd8, 5'd8, 4'd8, 2'b00});
        issue(1'b1, 2'b10, 0, 0, 1'b0);
        chk(32'(pre_ok[0]), 32'h0, "R6 target bank");
        chk(32'(pre_ok[1]), 32'h1, "R6 neighbour bank");
        chk(32'(pre_ok[8]), 32'h1, "R6 other rank");
        issue(1'b1, 2'b11, 2, 5, 1'b0);
        chk(32'(pre_ok[23:16]), 32'h0, "R6 PRE rank blocked");
        chk(32'(pre_ok[31:24]), 32'hFF, "R6 PRE other rank free");
        drain();

        // R7 reload
        wcfg({5'd0, 5'd6, 4'd0, 2'b00});
        issue(1'b1, 2'b01, 0, 1, 1'b0);
        repeat (3) @(negedge clk);
        issue(1'b1, 2'b01, 0, 1, 1'b0);
        repeat (4) @(negedge clk);
        chk(32'(pre_ok[1]), 32'h0, "R7 reloaded still blocked");
        @(negedge clk);
        chk(32'(pre_ok[1]), 32'h1, "R7 reloaded expires");
        drain();

        // R8 early PRE, sticky
        issue(1'b1, 2'b01, 0, 2, 1'b0);
        issue(1'b1, 2'b11, 0, 2, 1'b0);
        chk(32'(viol), 32'h1, "R8 early PRE sets flag");
        repeat (10) @(negedge clk);
        chk(32'(viol), 32'h1, "R8 flag sticky");

        // R9 clear and overlap
        issue(1'b0, 2'b00, 0, 0, 1'b1);
        chk(32'(viol), 32'h0, "R9 clear");
        issue(1'b1, 2'b11, 0, 2, 1'b0);
        chk(32'(viol), 32'h0, "R8 legal PRE no flag");
        issue(1'b1, 2'b01, 0, 2, 1'b0);
        issue(1'b1, 2'b11, 0, 2, 1'b1);
        chk(32'(viol), 32'h1, "R9 set wins over clear");
        issue(1'b0, 2'b00, 0, 0, 1'b1);
        drain();

        // R10 register change does not touch a running counter
        wcfg({5'd0, 5'd10, 4'd0, 2'b00});
        issue(1'b1, 2'b01, 1, 0, 1'b0);
        wcfg({5'd0, 5'd2, 4'd0, 2'b00});
        repeat (4) @(negedge clk);
        chk(32'(pre_ok[8]), 32'h0, "R10 old spacing kept");
        issue(1'b1, 2'b01, 1, 1, 1'b0);
        chk(32'(pre_ok[9]), 32'h0, "R10 new spacing j0");
        @(negedge clk);
        chk(32'(pre_ok[9]), 32'h1, "R10 new spacing j1");
        drain();

        // R11 ignored commands
        wcfg({5'd6, 5'd6, 4'd6, 2'b00});
        issue(1'b0, 2'b01, 2, 0, 1'b0);
        chk(pre_ok, 32'hFFFF_FFFF, "R11 valid low");
        issue(1'b1, 2'b00, 2, 0, 1'b0);
        chk(pre_ok, 32'hFFFF_FFFF, "R11 NOP");
        issue(1'b1, 2'b01, 2, 0, 1'b0);
        issue(1'b0, 2'b11, 2, 0, 1'b0);
        chk(32'(viol), 32'h0, "R11 invalid PRE no flag");
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule